// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to a 16-bit segment base. It keeps four segment registers: code, data, stack and extra. Each request carries an access kind. The kind picks the segment that goes with it, and the sum is the segment value times sixteen plus the offset. A carry out of the top bit is dropped, so every address stays inside the 1 MB space.

Software-visible state is limited to the four segment registers. Each one is loaded as a whole 16-bit word through a write port. A request may carry a segment override, which replaces the default choice for every kind except instruction fetch. The address is registered and appears one cycle after the request, together with a one-cycle valid pulse.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, `addr_out` is 0, `addr_valid` is 0 and all four segment registers hold 0.
- R2: A request produces `addr_out` = (segment × 16 + offset) taken to 20 bits. For example, segment 1005h with offset 5555h gives 155A5h, and segment 348Ah with offset 4214h gives 38AB4h.
- R3: A carry out of bit 19 is discarded. For example, FFFFh:FFFFh gives 0FFEFh and F800h:8000h gives 00000h.
- R4: Without an override, `req_kind` selects the segment as follows: 0 (instruction fetch) uses code, 1 (stack access) uses stack, 2 (data access) uses data, and 3 (string destination) uses extra.
- R5: When `ovr_valid` is 1 and `req_kind` is not 0, the segment named by `ovr_sel` is used instead. The encoding is 0 for code, 1 for data, 2 for stack and 3 for extra.
- R6: On an instruction fetch (`req_kind` 0), the override inputs have no effect and the code segment is always used.
- R7: When `seg_wr_en` is 1, the full 16-bit `seg_wr_data` is written into the segment register named by `seg_wr_sel`, using the same encoding as `ovr_sel`. Requests in later cycles see the new value. A request in the same cycle as the write sees the old value.
- R8: `addr_valid` goes high for exactly one cycle, in the cycle after each cycle with `req_valid` high. `addr_out` is updated in that same cycle.
- R9: While no request is made, `addr_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind (0 fetch, 1 stack, 2 data, 3 string destination) |
| req_offset | input | 16 | Offset added to the shifted segment |
| ovr_valid | input | 1 | Segment override present on this request |
| ovr_sel | input | 2 | Override segment (same encoding as seg_wr_sel) |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | One-cycle pulse marking a fresh address |

## Verification
The hardest case to reach from the ports is a segment write that lands in the same cycle as a request using that same segment. In that case the address must be built from the old value, and the new value must apply from the next request onwards. The stimulus sets up this collision on purpose. It also covers the two carry-wrapping sums and overrides that arrive together with a fetch. Long random stretches then mix writes, overrides, idle gaps and back-to-back requests, and a behavioural model checks every cycle.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_kind_e;

  localparam int unsigned NUM_SEG = 4;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  seg_id_e                        wr_sel,
  input  logic [SEG_W-1:0]               wr_data,
  output logic [NUM_SEG-1:0][SEG_W-1:0]  seg_q
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic             hit;
    logic [SEG_W-1:0] seg_d;

    always_comb begin
      hit   = wr_en && (wr_sel == seg_id_e'(g));
      seg_d = hit ? wr_data : seg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[g] <= '0;
      else        seg_q[g] <= seg_d;
    end

    // R7: a write stores the whole word
    a_r7_word_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == seg_id_e'(g)) |=> (seg_q[g] == $past(wr_data)));

    // R7: an unselected register keeps its value
    a_r7_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == seg_id_e'(g)) |=> $stable(seg_q[g]));
  end

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  acc_kind_e                      kind,
  input  logic                           ovr_valid,
  input  seg_id_e                        ovr_sel,
  input  logic [NUM_SEG-1:0][SEG_W-1:0]  seg_q,
  output seg_id_e                        sel_id,
  output logic [SEG_W-1:0]               seg_val
);

  seg_id_e dflt_id;

  always_comb begin
    unique case (kind)
      ACC_FETCH:  dflt_id = SEG_CODE;
      ACC_STACK:  dflt_id = SEG_STACK;
      ACC_DATA:   dflt_id = SEG_DATA;
      ACC_STRDST: dflt_id = SEG_EXTRA;
      default:    dflt_id = SEG_CODE;
    endcase
  end

  always_comb begin
    if (ovr_valid && (kind != ACC_FETCH)) sel_id = ovr_sel;
    else                                  sel_id = dflt_id;
    seg_val = seg_q[sel_id];
  end

  // R6: fetches always resolve to the code segment
  always_comb begin
    a_r6_fetch_code: assert (kind != ACC_FETCH || sel_id == SEG_CODE);
  end

endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [SEG_W-1:0]         seg_val,
  input  logic [OFF_W-1:0]         offset,
  output logic [SEG_W+SHIFT-1:0]   addr_q,
  output logic                     valid_q
);

  localparam int unsigned ADDR_W = SEG_W + SHIFT;

  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] off_w;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    base_w  = {seg_val, {SHIFT{1'b0}}};
    off_w   = ADDR_W'(offset);
    addr_d  = base_w + off_w;
    addr_en = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= req_valid;
  end

  // R2: the low bits below the shift come straight from the offset
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (addr_q[SHIFT-1:0] == $past(offset[SHIFT-1:0])));

  // R9: the address holds while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(addr_q));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seg_wr_en,
  input  logic [1:0]             seg_wr_sel,
  input  logic [SEG_W-1:0]       seg_wr_data,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [OFF_W-1:0]       req_offset,
  input  logic                   ovr_valid,
  input  logic [1:0]             ovr_sel,
  output logic [SEG_W+SHIFT-1:0] addr_out,
  output logic                   addr_valid
);

  localparam int unsigned ADDR_W = SEG_W + SHIFT;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  seg_id_e                       sel_id;
  logic [SEG_W-1:0]              seg_val;
  logic [ADDR_W-1:0]             addr_q;
  logic                          valid_q;

  seg_regfile #(.SEG_W(SEG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_id_e'(seg_wr_sel)),
    .wr_data (seg_wr_data),
    .seg_q   (seg_q)
  );

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .kind      (acc_kind_e'(req_kind)),
    .ovr_valid (ovr_valid),
    .ovr_sel   (seg_id_e'(ovr_sel)),
    .seg_q     (seg_q),
    .sel_id    (sel_id),
    .seg_val   (seg_val)
  );

  phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .seg_val   (seg_val),
    .offset    (req_offset),
    .addr_q    (addr_q),
    .valid_q   (valid_q)
  );

  assign addr_out   = addr_q;
  assign addr_valid = valid_q;

  // R8: valid follows each request by one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> addr_valid);

  // R8: no valid without a request one cycle earlier
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !addr_valid);

endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_offset;
  logic        ovr_valid;
  logic [1:0]  ovr_sel;
  logic [19:0] addr_out;
  logic        addr_valid;

  always #5 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
    .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  int total = 0;
  int bad   = 0;
  int m_seg [4];
  int m_addr;
  int m_valid;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
    req_valid = 0; req_kind = 0; req_offset = 0;
    ovr_valid = 0; ovr_sel = 0;
  endtask

  // one clock: inputs already driven, model updates at the edge, compare at negedge
  task automatic cyc(input string tag);
    int sid;
    @(posedge clk);
    m_valid = req_valid;
    if (req_valid) begin
      if (req_kind == 0)   sid = 0;
      else if (ovr_valid)  sid = ovr_sel;
      else if (req_kind == 1) sid = 2;
      else if (req_kind == 2) sid = 1;
      else sid = 3;
      m_addr = (m_seg[sid] * 16 + req_offset) % (1 << 20);
    end
    if (seg_wr_en) m_seg[seg_wr_sel] = seg_wr_data;
    @(negedge clk);
    chk({tag, " valid"}, addr_valid, m_valid);
    chk({tag, " addr"},  addr_out,   m_addr);
    idle_in();
  endtask

  task automatic wr(input int s, input int v);
    seg_wr_en = 1; seg_wr_sel = s[1:0]; seg_wr_data = v[15:0];
  endtask

  task automatic rq(input int k, input int off, input int ov, input int os);
    req_valid = 1; req_kind = k[1:0]; req_offset = off[15:0];
    ovr_valid = ov[0]; ovr_sel = os[1:0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_seg[i] = 0;
    m_addr = 0; m_valid = 0;
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", addr_out, 0);
    chk("R1 reset valid", addr_valid, 0);
    // R1: segments start at zero
    rq(0, 'h1234, 0, 0); cyc("R1 zero code seg");
    rq(3, 'h0042, 0, 0); cyc("R1 zero extra seg");
    // R2 / R4
    wr(1, 'h1005); cyc("R7 write data");
    rq(2, 'h5555, 0, 0); cyc("R2 155A5 data");
    wr(0, 'h348A); cyc("R7 write code");
    rq(0, 'h4214, 0, 0); cyc("R2 38AB4 fetch");
    wr(2, 'h2000); cyc("R7 write stack");
    wr(3, 'h3000); cyc("R7 write extra");
    rq(1, 'h0010, 0, 0); cyc("R4 stack kind");
    rq(3, 'h0001, 0, 0); cyc("R4 string dest kind");
    rq(2, 'h0002, 0, 0); cyc("R4 data kind");
    // R3 wrap
    wr(1, 'hFFFF); cyc("R7 write data FFFF");
    rq(2, 'hFFFF, 0, 0); cyc("R3 wrap FFFF:FFFF");
    wr(2, 'hF800); cyc("R7 write stack F800");
    rq(1, 'h8000, 0, 0); cyc("R3 wrap to zero");
    // R5 overrides
    rq(2, 'h0100, 1, 2); cyc("R5 data with stack ovr");
    rq(3, 'h0200, 1, 0); cyc("R5 strdst with code ovr");
    rq(1, 'h0300, 1, 3); cyc("R5 stack with extra ovr");
    // R6 fetch ignores override
    rq(0, 'h0400, 1, 3); cyc("R6 fetch ovr extra");
    rq(0, 'h0500, 1, 1); cyc("R6 fetch ovr data");
    // R7 collision: write data segment while data request
    wr(1, 'h4000); rq(2, 'h0000, 0, 0); cyc("R7 same-cycle old value");
    rq(2, 'h0000, 0, 0); cyc("R7 next uses new value");
    // R8 back-to-back then R9 idle hold
    rq(0, 'h0001, 0, 0); cyc("R8 b2b first");
    rq(0, 'h0002, 0, 0); cyc("R8 b2b second");
    cyc("R8 valid drops");
    cyc("R9 hold 1");
    wr(0, 'h7777); cyc("R9 hold during write");
    cyc("R9 hold 2");
    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 3), $urandom_range(0, 'hFFFF));
      if ($urandom_range(0, 2) != 0)
        rq($urandom_range(0, 3), $urandom_range(0, 'hFFFF),
           $urandom_range(0, 1), $urandom_range(0, 3));
      cyc("R2 R4 R5 R8 random");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule